// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of an eight-channel DMA engine and decides which channel the engine serves next. Each channel has three request sources: a single-transfer request line and a burst request line from its peripheral, and a one-cycle software request pulse. Per-channel control vectors from the register bank qualify these sources. They set whether the channel is enabled, whether its peripheral lines are masked, whether single requests are ignored (burst-only), which priority level it uses, and whether it waits for the requester to let go. A global enable gates everything.

Among the qualified channels the arbiter picks one in two levels. Any high-level channel beats every default-level channel, and within a level the lowest channel number wins. The block registers the winner with its request kind and its transfer count, which is 2^R for burst-type service and 1 for single service, R being the channel's rate field. It holds that grant through the engine's start/complete handshake. It reports one active channel at a time. A channel with its wait bit set stays active after completion until both of its peripheral request lines are low, so a slow or asynchronous requester can see the handshake close.

Top module: `dma_req_arb`

## Requirements
- R1: No grant is issued while `master_en` is low, and a channel whose `chan_en` bit is low is never granted.
- R2: A set `req_mask` bit keeps both `sreq` and `breq` of that channel from raising a request; clearing the bit lets a still-held request through.
- R3: A set `burst_only` bit makes the channel ignore `sreq`, while `breq` still raises a request.
- R4: A `sw_req` pulse is remembered per channel until that channel is granted, raises a request regardless of `req_mask`, `burst_only` and the peripheral lines, and is served as burst type (`grant_burst` = 1). It is cleared by its own grant.
- R5: When any eligible channel has its `hi_prio` bit set, the lowest-numbered such channel wins; otherwise the lowest-numbered eligible channel wins.
- R6: From the idle state an eligible request seen at a clock edge shows as `grant_valid` = 1 after that edge. The grant outputs stay constant until an `eng_done` pulse that follows an `eng_start` pulse. An `eng_done` before `eng_start` is ignored. `grant_valid` drops after the edge that takes the accepted `eng_done`.
- R7: `grant_burst` is 1 when the grant was for burst-type service (burst line or software request) and then `grant_xfers` = 2^R, where R is the channel's `RATE_W`-bit field at `arb_rate[ch*RATE_W +: RATE_W]`. For single service `grant_burst` = 0 and `grant_xfers` = 1.
- R8: With `wait_req` clear, the channel leaves the active state on the edge that takes `eng_done` even if its request lines are still high, and it may be granted again on the next edge.
- R9: With `wait_req` set and `sreq` or `breq` of the channel still high at completion, the channel stays active with `grant_valid` = 0 and no other channel is granted. It leaves on the edge where both lines are seen low.
- R10: `chan_active` has at most one bit set. While a channel is granted or held, it is the bit of `grant_chan`; after reset it is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global enable for granting |
| chan_en | input | N | Per-channel enable |
| req_mask | input | N | Per-channel mask of the peripheral request lines |
| burst_only | input | N | Per-channel: ignore single requests |
| hi_prio | input | N | Per-channel: use the high priority level |
| wait_req | input | N | Per-channel: stay active until request lines drop |
| arb_rate | input | N*RATE_W | Per-channel rate R; burst service moves 2^R items |
| sreq | input | N | Peripheral single-transfer request lines |
| breq | input | N | Peripheral burst request lines |
| sw_req | input | N | Software request pulses |
| eng_start | input | 1 | Engine has started the granted service |
| eng_done | input | 1 | Engine has completed the granted service |
| grant_valid | output | 1 | A grant is outstanding |
| grant_chan | output | $clog2(N) | Granted channel number |
| grant_burst | output | 1 | 1 = burst-type service, 0 = single |
| grant_xfers | output | 1<<RATE_W | Number of items for this service |
| chan_active | output | N | One-hot active channel |

## Verification
Two functions that meet in one cycle are the end of a transfer and the arrival of a competing request. A higher-ranked software request and an early `eng_done` are driven while a grant waits for `eng_start`, and the bench judges that the grant outputs do not move and that the new request is served only after the real completion. The wait-on-request hold is provoked with a lower-numbered channel already requesting, and the bench judges that no grant appears until the held channel's lines are low, then that the waiting channel follows one edge later.

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
  parameter int N      = 8,
  parameter int RATE_W = 4,
  localparam int CW    = $clog2(N),
  localparam int XW    = 1 << RATE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_en,
  input  logic [N-1:0]    chan_en,
  input  logic [N-1:0]    req_mask,
  input  logic [N-1:0]    burst_only,
  input  logic [N-1:0]    hi_prio,
  input  logic [N-1:0]    wait_req,
  input  logic [N*RATE_W-1:0] arb_rate,
  input  logic [N-1:0]    sreq,
  input  logic [N-1:0]    breq,
  input  logic [N-1:0]    sw_req,
  input  logic            eng_start,
  input  logic            eng_done,
  output logic            grant_valid,
  output logic [CW-1:0]   grant_chan,
  output logic            grant_burst,
  output logic [XW-1:0]   grant_xfers,
  output logic [N-1:0]    chan_active
);

  typedef enum logic [1:0] {S_IDLE, S_GRANT, S_BUSY, S_HOLD} st_t;
  st_t state;

  logic [N-1:0] sw_pend, ext_b, ext_s, burst_src, elig, hi_elig, pool, pick_oh;
  logic [CW-1:0] pick;
  logic [RATE_W-1:0] pick_rate;
  logic take, line_held;

  assign ext_b     = breq & ~req_mask;
  assign ext_s     = sreq & ~req_mask & ~burst_only;
  assign burst_src = sw_pend | ext_b;
  assign elig      = {N{master_en}} & chan_en & (burst_src | ext_s);
  assign hi_elig   = elig & hi_prio;
  assign pool      = (|hi_elig) ? hi_elig : elig;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pool[i]) pick = CW'(i);
  end

  assign pick_oh   = N'(1) << pick;
  assign pick_rate = arb_rate[pick*RATE_W +: RATE_W];
  assign take      = (state == S_IDLE) && (|elig);
  assign line_held = sreq[grant_chan] | breq[grant_chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= '0;
    else        sw_pend <= (sw_pend & ~(take ? pick_oh : '0)) | sw_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      grant_chan  <= '0;
      grant_burst <= 1'b0;
      grant_xfers <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (take) begin
            state       <= S_GRANT;
            grant_chan  <= pick;
            grant_burst <= burst_src[pick];
            grant_xfers <= burst_src[pick] ? (XW'(1) << pick_rate) : XW'(1);
          end
        S_GRANT:
          if (eng_start) state <= S_BUSY;
        S_BUSY:
          if (eng_done) state <= (wait_req[grant_chan] && line_held) ? S_HOLD : S_IDLE;
        S_HOLD:
          if (!line_held) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign grant_valid = (state == S_GRANT) || (state == S_BUSY);
  assign chan_active = (state != S_IDLE) ? (N'(1) << grant_chan) : '0;

endmodule

// File: rtl/dma_req_arb_chk.sv
module dma_req_arb_chk #(
  parameter int N      = 8,
  parameter int RATE_W = 4,
  localparam int CW    = $clog2(N),
  localparam int XW    = 1 << RATE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_en,
  input logic [N-1:0]  chan_en,
  input logic [N-1:0]  req_mask,
  input logic [N-1:0]  burst_only,
  input logic [N-1:0]  wait_req,
  input logic [N-1:0]  sreq,
  input logic [N-1:0]  breq,
  input logic          eng_done,
  input logic          grant_valid,
  input logic [CW-1:0] grant_chan,
  input logic          grant_burst,
  input logic [XW-1:0] grant_xfers,
  input logic [N-1:0]  chan_active
);

  assert_onehot_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_active));

  assert_grant_is_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> chan_active == (N'(1) << grant_chan));

  assert_enabled_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(master_en) && $past(chan_en[grant_chan]));

  assert_single_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && !grant_burst) |->
      $past(!burst_only[grant_chan] && !req_mask[grant_chan]));

  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !eng_done) |=>
      grant_valid && $stable(grant_chan) && $stable(grant_burst) && $stable(grant_xfers));

  assert_single_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_burst) |-> grant_xfers == XW'(1));

  for (genvar c = 0; c < N; c++) begin : g_hold
    assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_active[c] && !grant_valid && (sreq[c] || breq[c])) |=> chan_active[c] && !grant_valid);
  end

endmodule

bind dma_req_arb dma_req_arb_chk #(.N(N), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .chan_en(chan_en),
  .req_mask(req_mask), .burst_only(burst_only), .wait_req(wait_req),
  .sreq(sreq), .breq(breq), .eng_done(eng_done), .grant_valid(grant_valid),
  .grant_chan(grant_chan), .grant_burst(grant_burst), .grant_xfers(grant_xfers),
  .chan_active(chan_active)
);

// File: tb/test_dma_req_arb.sv
`timescale 1ns/1ps
module test_dma_req_arb;
  localparam int N = 8, RW = 4, CW = 3, XW = 16;

  logic clk = 0, rst_n = 0, master_en = 0, eng_start = 0, eng_done = 0;
  logic [N-1:0] chan_en = '0, req_mask = '0, burst_only = '0, hi_prio = '0, wait_req = '0;
  logic [N-1:0] sreq = '0, breq = '0, sw_req = '0;
  logic [N*RW-1:0] arb_rate = '0;
  logic grant_valid, grant_burst;
  logic [CW-1:0] grant_chan;
  logic [XW-1:0] grant_xfers;
  logic [N-1:0] chan_active;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  dma_req_arb #(.N(N), .RATE_W(RW)) i_dma_req_arb (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .chan_en(chan_en),
    .req_mask(req_mask), .burst_only(burst_only), .hi_prio(hi_prio),
    .wait_req(wait_req), .arb_rate(arb_rate), .sreq(sreq), .breq(breq),
    .sw_req(sw_req), .eng_start(eng_start), .eng_done(eng_done),
    .grant_valid(grant_valid), .grant_chan(grant_chan), .grant_burst(grant_burst),
    .grant_xfers(grant_xfers), .chan_active(chan_active));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_xfer();
    eng_start = 1; cyc(1); eng_start = 0;
    eng_done = 1;  cyc(1); eng_done = 0;
  endtask

  task automatic t_reset();
    check("R10 reset grant_valid", grant_valid, 0);
    check("R10 reset chan_active", chan_active, 0);
  endtask

  task automatic t_enable();
    chan_en = '1; sreq = 8'h04; cyc(3);
    check("R1 master off", grant_valid, 0);
    master_en = 1; chan_en = 8'hFB; cyc(3);
    check("R1 channel off", grant_valid, 0);
    chan_en = '1; cyc(1);
    check("R6 one-edge latency", grant_valid, 1);
    check("R1 chan", grant_chan, 2);
    check("R7 single kind", grant_burst, 0);
    check("R7 single count", grant_xfers, 1);
    check("R10 active", chan_active, 8'h04);
    sreq = 0; finish_xfer();
    check("R6 drop after done", grant_valid, 0);
    check("R10 idle active", chan_active, 0);
  endtask

  task automatic t_mask();
    req_mask = 8'h08; sreq = 8'h08; breq = 8'h08; cyc(3);
    check("R2 masked", grant_valid, 0);
    sw_req = 8'h08; cyc(1); sw_req = 0; cyc(1);
    check("R4 sw grant", grant_valid, 1);
    check("R4 sw chan", grant_chan, 3);
    check("R4 sw burst", grant_burst, 1);
    finish_xfer(); cyc(2);
    check("R4 latch cleared", grant_valid, 0);
    req_mask = 0; cyc(1);
    check("R2 unmask", grant_valid, 1);
    check("R2 unmask chan", grant_chan, 3);
    sreq = 0; breq = 0; finish_xfer();
  endtask

  task automatic t_burst();
    burst_only = 8'h02; sreq = 8'h02; cyc(3);
    check("R3 single ignored", grant_valid, 0);
    arb_rate[1*RW +: RW] = 4'd3; breq = 8'h02; cyc(1);
    check("R3 burst taken", grant_valid, 1);
    check("R3 chan", grant_chan, 1);
    check("R7 burst kind", grant_burst, 1);
    check("R7 burst count", grant_xfers, 8);
    sreq = 0; breq = 0; finish_xfer();
    burst_only = 0;
  endtask

  task automatic t_prio();
    hi_prio = 8'h60; sreq = 8'h62; cyc(1);
    check("R5 low index high level", grant_chan, 5);
    sreq = 8'h42; finish_xfer(); cyc(1);
    check("R5 next high", grant_chan, 6);
    sreq = 8'h02; finish_xfer(); cyc(1);
    check("R5 default level", grant_chan, 1);
    hi_prio = 8'h80; sreq = 8'h81; finish_xfer(); cyc(1);
    check("R5 high beats index", grant_chan, 7);
    sreq = 0; finish_xfer(); hi_prio = 0;
  endtask

  task automatic t_hold();
    sreq = 8'h08; cyc(1);
    check("R6 granted", grant_chan, 3);
    sw_req = 8'h01; cyc(1); sw_req = 0;
    eng_done = 1; cyc(1); eng_done = 0;
    check("R6 early done ignored", grant_valid, 1);
    check("R6 chan stable", grant_chan, 3);
    eng_start = 1; cyc(1); eng_start = 0; cyc(3);
    check("R6 held busy", grant_chan, 3);
    sreq = 0; eng_done = 1; cyc(1); eng_done = 0;
    check("R6 released", grant_valid, 0);
    cyc(1);
    check("R4 pending served", grant_chan, 0);
    check("R4 pending burst", grant_burst, 1);
    finish_xfer();
  endtask

  task automatic t_nowait();
    sreq = 8'h10; cyc(1);
    check("R8 granted", grant_chan, 4);
    finish_xfer();
    check("R8 leaves active", chan_active, 0);
    cyc(1);
    check("R8 regrant", grant_valid, 1);
    sreq = 0; finish_xfer();
  endtask

  task automatic t_wait();
    wait_req = 8'h10; sreq = 8'h10; breq = 8'h10; cyc(1);
    check("R9 granted", grant_chan, 4);
    finish_xfer();
    check("R9 held active", chan_active, 8'h10);
    check("R9 no grant", grant_valid, 0);
    sreq = 8'h11; cyc(3);
    check("R9 blocks others", grant_valid, 0);
    sreq = 8'h01; cyc(2);
    check("R9 burst line holds", chan_active, 8'h10);
    breq = 0; cyc(1);
    check("R9 released", chan_active, 0);
    cyc(1);
    check("R9 next grant", grant_chan, 0);
    sreq = 0; finish_xfer(); wait_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    cyc(3); t_reset();
    rst_n = 1; cyc(2);
    t_enable();
    t_mask();
    t_burst();
    t_prio();
    t_hold();
    t_nowait();
    t_wait();
    cyc(2);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule